// File: doc/BRIEF.md
# Configurable GPIO Port Register Block

This block is one eight-pin general-purpose I/O port on a microcontroller-style register bus. It holds three registers: an output data latch, a per-pin input-mode register that selects analog or digital input, and a per-pin output-mode register that selects open-drain or push-pull drive. Every pin pad is modelled as three separate signals: a driven value, a drive enable and a sampled input. The block also reports which pins have their weak pullup switched on.

The CPU side writes a register either as a whole byte or one latch bit at a time, and reads through a combinational read port. An ordinary read of the data register returns the synchronized pin levels. A read flagged as the first phase of a read-modify-write returns the latch instead, so the write-back does not copy external levels into the latch. Pins in analog mode read as zero and lose their pullup. A single global input turns all pullups off.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the data latch is 0xFF, the input-mode register is 0xFF (all digital), the output-mode register is 0x00 (all open-drain), and `pin_oe` is 0x00.
- R2: With `reg_sel`=0 (data) and `rmw`=0, `rdata` bit i equals the level of `pin_in` bit i two rising clock edges earlier, for every digital pin.
- R3: With `reg_sel`=0 and `rmw`=1, `rdata` equals the data latch, whatever the pin levels and the input modes.
- R4: A pin whose input-mode bit is 0 (analog) reads as 0 on an ordinary data read, whatever its level.
- R5: `pullup_en` bit i is 1 exactly when input-mode bit i is 1, `pullup_off` is 0 and pin i is not being driven low.
- R6: A pin with output-mode bit 0 (open-drain) has `pin_oe`=1 and `pin_out`=0 when its latch bit is 0 and `pin_oe`=0 when its latch bit is 1. A pin with output-mode bit 1 (push-pull) has `pin_oe`=1 and `pin_out` equal to its latch bit.
- R7: `wr_byte` loads `wdata` into the register that `reg_sel` selects (0 data, 1 input mode, 2 output mode) at the next edge, and reading with the same `reg_sel` returns that value. `reg_sel`=3 reads 0 and its writes have no effect.
- R8: `wr_bit` without `wr_byte` sets latch bit `bit_idx` to `bit_val` and leaves the other seven latch bits unchanged. When both strobes are high, the byte write applies and the bit write is dropped.
- R9: `rbit` equals bit `bit_idx` of `rdata` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 data, 1 input mode, 2 output mode |
| wr_byte | input | 1 | Byte write strobe for the selected register |
| wdata | input | 8 | Byte write data |
| wr_bit | input | 1 | Single-bit write strobe to the data latch |
| bit_idx | input | 3 | Bit index for bit write and bit read |
| bit_val | input | 1 | Value for bit write |
| rmw | input | 1 | Read is the first phase of a read-modify-write |
| pullup_off | input | 1 | Global weak-pullup disable |
| rdata | output | 8 | Read data of the selected register |
| rbit | output | 1 | Selected bit of the read data |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pullup_en | output | 8 | Weak pullup active per pin |

## Verification
Register writes show up on `rdata`, `pin_out`, `pin_oe` and `pullup_en` one edge after the strobe. The bench drives every input on the falling edge, steps one rising edge and samples on the next falling edge. A pin level reaches `rdata` only after the second rising edge, so the pin-read test checks the old value after one edge and the new value after two. Read muxing, `rmw` and `reg_sel` changes are combinational and are checked in the same half cycle in which they are driven.

// File: rtl/gpio_port_pkg.sv
// Package: shared register-select encoding for the GPIO port block.
// Assumes a two-bit select field on the register bus.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SEL_DATA    = 2'd0,
        SEL_INMODE  = 2'd1,
        SEL_OUTMODE = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
// Module: two-flop synchronizer per pin input.
// Assumes asynchronous pad levels; output lags input by two rising edges.
module gpio_pin_sync #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] async_in,
    output logic [PINS-1:0] sync_out
);

    logic [PINS-1:0] meta_q;
    logic [PINS-1:0] sync_q;

    // Two flops in series; reset to all ones to match released pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;

endmodule

// File: rtl/gpio_port_store.sv
// Module: data latch, input-mode and output-mode registers.
// Assumes byte write has priority over bit write when both are strobed.
module gpio_port_store
    import gpio_port_pkg::*;
#(
    parameter int              PINS        = 8,
    parameter int              IDXW        = (PINS > 1) ? $clog2(PINS) : 1,
    parameter logic [PINS-1:0] LATCH_INIT  = '1,
    parameter logic [PINS-1:0] INMODE_INIT = '1,
    parameter logic [PINS-1:0] OUTMODE_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  reg_sel_e        sel,
    input  logic            wr_byte,
    input  logic [PINS-1:0] wdata,
    input  logic            wr_bit,
    input  logic [IDXW-1:0] bit_idx,
    input  logic            bit_val,
    output logic [PINS-1:0] latch_q,
    output logic [PINS-1:0] inmode_q,
    output logic [PINS-1:0] outmode_q
);

    // Data latch: byte write first, else single-bit update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= LATCH_INIT;
        end else if (wr_byte && sel == SEL_DATA) begin
            latch_q <= wdata;
        end else if (wr_bit && !wr_byte) begin
            for (int i = 0; i < PINS; i++) begin
                if (bit_idx == IDXW'(i)) latch_q[i] <= bit_val;
            end
        end
    end

    // Input-mode register: byte writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inmode_q <= INMODE_INIT;
        end else if (wr_byte && sel == SEL_INMODE) begin
            inmode_q <= wdata;
        end
    end

    // Output-mode register: byte writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outmode_q <= OUTMODE_INIT;
        end else if (wr_byte && sel == SEL_OUTMODE) begin
            outmode_q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: per-pin drive and pullup control.
// Assumes latch and mode bits are registered upstream; purely combinational.
module gpio_pad_ctrl #(
    parameter int PINS = 8
) (
    input  logic [PINS-1:0] latch,
    input  logic [PINS-1:0] inmode,
    input  logic [PINS-1:0] outmode,
    input  logic            pullup_off,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_pullup
);

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic drives_low;

        // Drive: push-pull always enabled; open-drain only enabled for a low.
        always_comb begin
            pad_out[g]  = latch[g];
            pad_oe[g]   = outmode[g] | ~latch[g];
            drives_low  = pad_oe[g] & ~pad_out[g];
        end

        // Pullup: digital pin, globally allowed, not driven low.
        always_comb begin
            pad_pullup[g] = inmode[g] & ~pullup_off & ~drives_low;
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
// Module: top of the GPIO port; register store, input sync, pad control, read mux.
// Assumes a combinational read port and that rmw is valid with the read.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8,
    parameter int IDXW = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      reg_sel,
    input  logic            wr_byte,
    input  logic [PINS-1:0] wdata,
    input  logic            wr_bit,
    input  logic [IDXW-1:0] bit_idx,
    input  logic            bit_val,
    input  logic            rmw,
    input  logic            pullup_off,
    output logic [PINS-1:0] rdata,
    output logic            rbit,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic [PINS-1:0] pullup_en
);

    reg_sel_e        sel;
    logic [PINS-1:0] latch_q;
    logic [PINS-1:0] inmode_q;
    logic [PINS-1:0] outmode_q;
    logic [PINS-1:0] pin_sync;

    assign sel = reg_sel_e'(reg_sel);

    gpio_port_store #(
        .PINS (PINS),
        .IDXW (IDXW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr_byte   (wr_byte),
        .wdata     (wdata),
        .wr_bit    (wr_bit),
        .bit_idx   (bit_idx),
        .bit_val   (bit_val),
        .latch_q   (latch_q),
        .inmode_q  (inmode_q),
        .outmode_q (outmode_q)
    );

    gpio_pin_sync #(
        .PINS (PINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_pad_ctrl #(
        .PINS (PINS)
    ) u_pad (
        .latch      (latch_q),
        .inmode     (inmode_q),
        .outmode    (outmode_q),
        .pullup_off (pullup_off),
        .pad_out    (pin_out),
        .pad_oe     (pin_oe),
        .pad_pullup (pullup_en)
    );

    // Read mux: pins for plain data reads, latch for rmw reads, mode registers direct.
    always_comb begin
        unique case (sel)
            SEL_DATA:    rdata = rmw ? latch_q : (pin_sync & inmode_q);
            SEL_INMODE:  rdata = inmode_q;
            SEL_OUTMODE: rdata = outmode_q;
            default:     rdata = '0;
        endcase
    end

    // Bit read: selected bit of the current read data.
    assign rbit = rdata[bit_idx];

endmodule

// File: rtl/gpio_port_chk.sv
// Module: assertion checker for gpio_port_regs, attached by bind.
// Assumes access to the internal register values through the bind connections.
module gpio_port_chk #(
    parameter int PINS = 8,
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      reg_sel,
    input logic            wr_byte,
    input logic            wr_bit,
    input logic [IDXW-1:0] bit_idx,
    input logic            rmw,
    input logic            pullup_off,
    input logic [PINS-1:0] rdata,
    input logic [PINS-1:0] pin_out,
    input logic [PINS-1:0] pin_oe,
    input logic [PINS-1:0] pullup_en,
    input logic [PINS-1:0] latch_q,
    input logic [PINS-1:0] inmode_q,
    input logic [PINS-1:0] outmode_q
);

    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (latch_q == '1 && inmode_q == '1 && outmode_q == '0 && pin_oe == '0)); // R1

    AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd0 && !rmw) |-> ((rdata & ~inmode_q) == '0)); // R4

    AST_OPEN_DRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((~outmode_q & pin_oe & pin_out) == '0)); // R6

    AST_PULLUP_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pullup_en & pin_oe & ~pin_out) == '0)); // R5

    AST_PULLUP_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_off |-> (pullup_en == '0)); // R5

    AST_BIT_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bit && !wr_byte) |=>
            (((latch_q ^ $past(latch_q)) & ~(PINS'(1) << $past(bit_idx))) == '0)); // R8

endmodule

bind gpio_port_regs gpio_port_chk #(
    .PINS (PINS),
    .IDXW (IDXW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .wr_byte    (wr_byte),
    .wr_bit     (wr_bit),
    .bit_idx    (bit_idx),
    .rmw        (rmw),
    .pullup_off (pullup_off),
    .rdata      (rdata),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pullup_en  (pullup_en),
    .latch_q    (latch_q),
    .inmode_q   (inmode_q),
    .outmode_q  (outmode_q)
);

// File: tb/gpio_port_regs_tb.sv
// Directed bench for gpio_port_regs: one task per scenario, inputs on the falling edge.
module gpio_port_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] reg_sel;
    logic       wr_byte;
    logic [7:0] wdata;
    logic       wr_bit;
    logic [2:0] bit_idx;
    logic       bit_val;
    logic       rmw;
    logic       pullup_off;
    logic [7:0] rdata;
    logic       rbit;
    logic [7:0] pin_in;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] pullup_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_port_regs u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .wr_byte    (wr_byte),
        .wdata      (wdata),
        .wr_bit     (wr_bit),
        .bit_idx    (bit_idx),
        .bit_val    (bit_val),
        .rmw        (rmw),
        .pullup_off (pullup_off),
        .rdata      (rdata),
        .rbit       (rbit),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .pullup_en  (pullup_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [1:0] sel, input logic [7:0] val);
        reg_sel = sel; wdata = val; wr_byte = 1'b1;
        step();
        wr_byte = 1'b0;
    endtask

    task automatic write_bit(input logic [2:0] idx, input logic val);
        bit_idx = idx; bit_val = val; wr_bit = 1'b1;
        step();
        wr_bit = 1'b0;
    endtask

    task automatic t_reset();
        reg_sel = 2'd0; rmw = 1'b1;
        #1 check("R1 latch", rdata, 8'hFF);
        rmw = 1'b0; reg_sel = 2'd1;
        #1 check("R1 inmode", rdata, 8'hFF);
        reg_sel = 2'd2;
        #1 check("R1 outmode", rdata, 8'h00);
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pullup", pullup_en, 8'hFF);
    endtask

    task automatic t_pin_read();
        reg_sel = 2'd0; rmw = 1'b0;
        pin_in = 8'h3C;
        step();
        check("R2 one edge old", rdata, 8'hA5);
        step();
        check("R2 two edges new", rdata, 8'h3C);
        pin_in = 8'hC3;
        step(); step();
        check("R2 pattern2", rdata, 8'hC3);
    endtask

    task automatic t_rmw();
        write_byte(2'd0, 8'h5A);
        pin_in = 8'h0F;
        step(); step();
        reg_sel = 2'd0; rmw = 1'b1;
        #1 check("R3 rmw latch", rdata, 8'h5A);
        rmw = 1'b0;
        #1 check("R3 plain pins", rdata, 8'h0F);
        write_byte(2'd1, 8'h00);
        reg_sel = 2'd0; rmw = 1'b1;
        #1 check("R3 rmw analog", rdata, 8'h5A);
        rmw = 1'b0;
        write_byte(2'd1, 8'hFF);
    endtask

    task automatic t_analog();
        pin_in = 8'hFF;
        step(); step();
        write_byte(2'd1, 8'hF0);
        reg_sel = 2'd0;
        #1 check("R4 analog zero", rdata, 8'hF0);
        write_byte(2'd1, 8'hFF);
    endtask

    task automatic t_drive();
        write_byte(2'd2, 8'h00);
        write_byte(2'd0, 8'h96);
        check("R6 od oe", pin_oe, 8'h69);
        check("R6 od out low", pin_out & pin_oe, 8'h00);
        write_byte(2'd2, 8'hFF);
        check("R6 pp oe", pin_oe, 8'hFF);
        check("R6 pp out", pin_out, 8'h96);
    endtask

    task automatic t_pullup();
        write_byte(2'd2, 8'h0F);
        write_byte(2'd0, 8'h33);
        write_byte(2'd1, 8'h7E);
        pullup_off = 1'b0;
        #1 check("R5 pullup", pullup_en, 8'h32);
        pullup_off = 1'b1;
        #1 check("R5 global off", pullup_en, 8'h00);
        pullup_off = 1'b0;
        write_byte(2'd1, 8'hFF);
    endtask

    task automatic t_bytes();
        write_byte(2'd2, 8'hA1);
        reg_sel = 2'd2;
        #1 check("R7 outmode readback", rdata, 8'hA1);
        write_byte(2'd3, 8'h00);
        reg_sel = 2'd3;
        #1 check("R7 sel3 reads zero", rdata, 8'h00);
        reg_sel = 2'd2;
        #1 check("R7 sel3 no effect outmode", rdata, 8'hA1);
        reg_sel = 2'd1;
        #1 check("R7 sel3 no effect inmode", rdata, 8'hFF);
    endtask

    task automatic t_bits();
        write_byte(2'd0, 8'h00);
        write_bit(3'd5, 1'b1);
        reg_sel = 2'd0; rmw = 1'b1;
        #1 check("R8 set bit5", rdata, 8'h20);
        write_bit(3'd0, 1'b1);
        #1 check("R8 set bit0", rdata, 8'h21);
        write_bit(3'd5, 1'b0);
        #1 check("R8 clear bit5", rdata, 8'h01);
        reg_sel = 2'd0; wdata = 8'hC0; wr_byte = 1'b1;
        bit_idx = 3'd1; bit_val = 1'b1; wr_bit = 1'b1;
        step();
        wr_byte = 1'b0; wr_bit = 1'b0;
        #1 check("R8 byte wins", rdata, 8'hC0);
        rmw = 1'b0;
    endtask

    task automatic t_rbit();
        write_byte(2'd2, 8'h24);
        reg_sel = 2'd2; bit_idx = 3'd2;
        #1 check("R9 rbit one", {7'd0, rbit}, 8'h01);
        bit_idx = 3'd3;
        #1 check("R9 rbit zero", {7'd0, rbit}, 8'h00);
        bit_idx = 3'd5;
        #1 check("R9 rbit five", {7'd0, rbit}, 8'h01);
    endtask

    initial begin
        rst_n = 1'b0; reg_sel = 2'd0; wr_byte = 1'b0; wdata = 8'h00;
        wr_bit = 1'b0; bit_idx = 3'd0; bit_val = 1'b0; rmw = 1'b0;
        pullup_off = 1'b0; pin_in = 8'hA5;
        @(negedge clk); step(); step();
        rst_n = 1'b1;
        t_reset();
        step(); step();
        t_pin_read();
        t_rmw();
        t_analog();
        t_drive();
        t_pullup();
        t_bytes();
        t_bits();
        t_rbit();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule